// File: doc/BRIEF.md
# Low-Power State Entry/Exit Sequencer

This block follows a memory device through its two sleep states, a shallow nap and a deep power-down. Entry requests come from decoded row command packets. Each request carries the target state and a relax flag. Exit requests come from a sideband command decoder. Each one carries a bit naming the state being left and a 6-bit device address. The address is not needed when broadcast wake-up is configured. The block records which awake state the device returns to, and it keeps the guard windows that follow every entry and every exit.

All timing runs on one fast clock. The slow sideband clock appears only as a one-fast-cycle tick strobe. The no-entry window after a sleep entry mixes fast cycles and slow ticks. For power-down, the slow term scales in steps of 256 ticks. The no-exit window after a wake-up also acts as the restricted interval, and row or column packets must stay out of it. Requests that break a window are dropped, and each kind of breach sets its own sticky flag. The flags stay set until an explicit clear.

Top module: `lps_seq_top`

## Requirements
- R1: After reset `pwr_state` is standby (code 1), both window outputs are 0 and all three violation flags are 0.
- R2: When the device is awake (state codes 0 active, 1 standby) and the entry window is closed, an entry request with kind 0 moves the state to nap (code 2) and kind 1 moves it to power-down (code 3) at the next edge.
- R3: After a nap entry, `entry_blocked` stays high for 5 fast cycles followed by (2 + `cfg_napx`) slow ticks. Ticks that fall in the first 5 cycles are not counted.
- R4: After a power-down entry, `entry_blocked` stays high for 5 fast cycles followed by (2 + 256 x `cfg_pdnx`) slow ticks.
- R5: An entry request made while `entry_blocked` is high leaves the state unchanged and sets the sticky `ent_viol` flag.
- R6: An exit request with kind bit 0 only wakes a device in nap. Kind bit 1 only wakes a device in power-down. An exit whose kind does not match the current state is ignored.
- R7: With `cfg_bcast` set, an exit applies without address checking. Otherwise it applies only when `exit_dev` equals `cfg_dev_id` and `cfg_slot` is 1.
- R8: On wake-up the state becomes standby (code 1) if the relax flag was 1 at entry, and active (code 0) if it was 0.
- R9: After an exit, `exit_blocked` stays high for 23 fast cycles when the long bit for the state just left is set (`cfg_nap_long` for nap, `cfg_pdn_long` for power-down). Otherwise it stays high for 8 − RATIO/2 fast cycles (at least 1), which is 6 with the default RATIO of 4.
- R10: An exit request made while `exit_blocked` is high is ignored and sets the sticky `exit_viol` flag.
- R11: A row or column packet that arrives while `exit_blocked` is high, or in the same cycle as an accepted exit, sets the sticky `pkt_viol` flag. A packet outside that interval leaves the flag unchanged.
- R12: `viol_clr` clears all three flags at the next edge. When a new violation arrives in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-fast-cycle strobe per slow clock period |
| cfg_napx | input | NAPX_W | Nap slow-term extension |
| cfg_pdnx | input | PDNX_W | Power-down multiplier (units of 256 slow ticks) |
| cfg_nap_long | input | 1 | Use the long exit window after a nap exit |
| cfg_pdn_long | input | 1 | Use the long exit window after a power-down exit |
| cfg_bcast | input | 1 | Exits need no address |
| cfg_slot | input | 1 | Address slot select; must be 1 for addressed exits |
| cfg_dev_id | input | 6 | This device's address |
| ent_valid | input | 1 | Entry request strobe |
| ent_kind | input | 1 | 0 nap, 1 power-down |
| ent_relax | input | 1 | Return to standby instead of active on wake-up |
| exit_valid | input | 1 | Exit request strobe |
| exit_kind | input | 1 | 0 leave nap, 1 leave power-down |
| exit_dev | input | 6 | Address carried by the exit |
| row_pkt | input | 1 | A row packet is on the bus this cycle |
| col_pkt | input | 1 | A column packet is on the bus this cycle |
| viol_clr | input | 1 | Clear the violation flags |
| pwr_state | output | 2 | 0 active, 1 standby, 2 nap, 3 power-down |
| entry_blocked | output | 1 | No-entry window open |
| exit_blocked | output | 1 | No-exit / restricted window open |
| ent_viol | output | 1 | Sticky: entry inside window |
| exit_viol | output | 1 | Sticky: exit inside window |
| pkt_viol | output | 1 | Sticky: packet inside restricted interval |

## Verification
There are two places where events can land in the same cycle. The first is an accepted wake-up arriving together with a column packet. In that cycle the window register has not yet risen, so `pkt_viol` must be set by the accept itself. The bench drives `exit_valid` and `col_pkt` in one cycle and requires the flag one edge later. The second is a flag clear meeting a fresh breach: the bench drives `viol_clr` together with a blocked entry and requires `ent_viol` to stay high. A later clear on its own must then drop the flag.

// File: rtl/lps_pkg.sv
package lps_pkg;

    localparam int DEV_W = 6;

    typedef enum logic [1:0] {
        PS_ACTIVE  = 2'd0,
        PS_STANDBY = 2'd1,
        PS_NAP     = 2'd2,
        PS_PDN     = 2'd3
    } pstate_e;

    typedef struct packed {
        logic valid;
        logic kind;
        logic relax;
    } ent_req_t;

    typedef struct packed {
        logic             valid;
        logic             kind;
        logic [DEV_W-1:0] dev;
    } exit_req_t;

    typedef struct packed {
        logic             bcast;
        logic             slot;
        logic [DEV_W-1:0] dev_id;
    } exit_cfg_t;

    function automatic logic is_asleep(pstate_e s);
        return (s == PS_NAP) || (s == PS_PDN);
    endfunction

    function automatic int exit_short_len(int base, int ratio);
        int v;
        v = base - ratio / 2;
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/lps_entry_gate.sv
module lps_entry_gate #(
    parameter int NAPX_W   = 4,
    parameter int PDNX_W   = 3,
    parameter int FAST_CYC = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              kind,
    input  logic              tick,
    input  logic [NAPX_W-1:0] napx,
    input  logic [PDNX_W-1:0] pdnx,
    output logic              busy
);
    localparam int FW = $clog2(FAST_CYC + 1);
    localparam int SW = (PDNX_W + 9 > NAPX_W + 2) ? PDNX_W + 9 : NAPX_W + 2;

    logic [FW-1:0] fcnt;
    logic [SW-1:0] scnt;
    logic [SW-1:0] load;

    // slow-term length: 2 + napx, or 2 + 256*pdnx
    always_comb begin
        if (kind)
            load = {{(SW - PDNX_W - 8){1'b0}}, pdnx, 8'd0} + SW'(2);
        else
            load = SW'(napx) + SW'(2);
    end

    // fast phase first, then slow ticks are counted
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            fcnt <= '0;
            scnt <= '0;
        end else if (start) begin
            busy <= 1'b1;
            fcnt <= FW'(FAST_CYC);
            scnt <= load;
        end else if (busy) begin
            if (fcnt != '0) begin
                fcnt <= fcnt - 1'b1;
            end else if (tick) begin
                scnt <= scnt - 1'b1;
                if (scnt == SW'(1))
                    busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lps_exit_gate.sv
module lps_exit_gate #(
    parameter int LONG_CYC  = 23,
    parameter int SHORT_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic long_sel,
    output logic busy
);
    localparam int MX = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CW = $clog2(MX + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= long_sel ? CW'(LONG_CYC) : CW'(SHORT_CYC);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/lps_state_fsm.sv
module lps_state_fsm
    import lps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ent_req_t  ent,
    input  exit_req_t ext,
    input  exit_cfg_t cfg,
    input  logic      ent_blk,
    input  logic      exit_blk,
    output pstate_e   state,
    output logic      ent_acc,
    output logic      exit_acc
);
    logic relax_q;
    logic addr_ok;
    logic kind_ok;

    always_comb begin
        addr_ok  = cfg.bcast || (cfg.slot && (ext.dev == cfg.dev_id));
        kind_ok  = ((state == PS_NAP) && !ext.kind) || ((state == PS_PDN) && ext.kind);
        exit_acc = ext.valid && !exit_blk && addr_ok && kind_ok;
        ent_acc  = ent.valid && !ent_blk && !is_asleep(state);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PS_STANDBY;
            relax_q <= 1'b0;
        end else if (exit_acc) begin
            state <= relax_q ? PS_STANDBY : PS_ACTIVE;
        end else if (ent_acc) begin
            state   <= ent.kind ? PS_PDN : PS_NAP;
            relax_q <= ent.relax;
        end
    end
endmodule

// File: rtl/lps_viol_flags.sv
module lps_viol_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (set[i])
                flags[i] <= 1'b1;
            else if (clr)
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/lps_seq_top.sv
module lps_seq_top
    import lps_pkg::*;
#(
    parameter int NAPX_W     = 4,
    parameter int PDNX_W     = 3,
    parameter int RATIO      = 4,
    parameter int ENT_FAST   = 5,
    parameter int EXIT_LONG  = 23,
    parameter int EXIT_BASE  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic [NAPX_W-1:0] cfg_napx,
    input  logic [PDNX_W-1:0] cfg_pdnx,
    input  logic              cfg_nap_long,
    input  logic              cfg_pdn_long,
    input  logic              cfg_bcast,
    input  logic              cfg_slot,
    input  logic [5:0]        cfg_dev_id,
    input  logic              ent_valid,
    input  logic              ent_kind,
    input  logic              ent_relax,
    input  logic              exit_valid,
    input  logic              exit_kind,
    input  logic [5:0]        exit_dev,
    input  logic              row_pkt,
    input  logic              col_pkt,
    input  logic              viol_clr,
    output logic [1:0]        pwr_state,
    output logic              entry_blocked,
    output logic              exit_blocked,
    output logic              ent_viol,
    output logic              exit_viol,
    output logic              pkt_viol
);
    localparam int EXIT_SHORT = exit_short_len(EXIT_BASE, RATIO);

    ent_req_t  ent;
    exit_req_t ext;
    exit_cfg_t ecfg;
    pstate_e   state;
    logic      ent_acc;
    logic      exit_acc;
    logic [2:0] vset;
    logic [2:0] vflags;

    assign ent  = '{valid: ent_valid, kind: ent_kind, relax: ent_relax};
    assign ext  = '{valid: exit_valid, kind: exit_kind, dev: exit_dev};
    assign ecfg = '{bcast: cfg_bcast, slot: cfg_slot, dev_id: cfg_dev_id};

    lps_state_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ent      (ent),
        .ext      (ext),
        .cfg      (ecfg),
        .ent_blk  (entry_blocked),
        .exit_blk (exit_blocked),
        .state    (state),
        .ent_acc  (ent_acc),
        .exit_acc (exit_acc)
    );

    lps_entry_gate #(
        .NAPX_W   (NAPX_W),
        .PDNX_W   (PDNX_W),
        .FAST_CYC (ENT_FAST)
    ) u_ent_gate (
        .clk   (clk),
        .rst   (rst),
        .start (ent_acc),
        .kind  (ent_kind),
        .tick  (slow_tick),
        .napx  (cfg_napx),
        .pdnx  (cfg_pdnx),
        .busy  (entry_blocked)
    );

    lps_exit_gate #(
        .LONG_CYC  (EXIT_LONG),
        .SHORT_CYC (EXIT_SHORT)
    ) u_exit_gate (
        .clk      (clk),
        .rst      (rst),
        .start    (exit_acc),
        .long_sel (exit_kind ? cfg_pdn_long : cfg_nap_long),
        .busy     (exit_blocked)
    );

    always_comb begin
        vset[0] = ent_valid && entry_blocked;
        vset[1] = exit_valid && exit_blocked;
        vset[2] = (row_pkt || col_pkt) && (exit_blocked || exit_acc);
    end

    lps_viol_flags #(.N(3)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .clr   (viol_clr),
        .set   (vset),
        .flags (vflags)
    );

    assign pwr_state = state;
    assign ent_viol  = vflags[0];
    assign exit_viol = vflags[1];
    assign pkt_viol  = vflags[2];
endmodule

// File: rtl/lps_seq_chk.sv
module lps_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       ent_valid,
    input logic       exit_valid,
    input logic       row_pkt,
    input logic       col_pkt,
    input logic       viol_clr,
    input logic [1:0] pwr_state,
    input logic       entry_blocked,
    input logic       exit_blocked,
    input logic       ent_viol,
    input logic       exit_viol,
    input logic       pkt_viol
);
    p_ent_viol_r5: assert property (@(posedge clk) disable iff (rst)
        (ent_valid && entry_blocked) |=> ent_viol);

    p_ent_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (ent_valid && entry_blocked && !exit_valid) |=> $stable(pwr_state));

    p_exit_viol_r10: assert property (@(posedge clk) disable iff (rst)
        (exit_valid && exit_blocked) |=> exit_viol);

    p_pkt_viol_r11: assert property (@(posedge clk) disable iff (rst)
        ((row_pkt || col_pkt) && exit_blocked) |=> pkt_viol);

    p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        ((ent_viol || exit_viol || pkt_viol) && !viol_clr) |=>
            (ent_viol || exit_viol || pkt_viol));

    p_wake_window_r9: assert property (@(posedge clk) disable iff (rst)
        (pwr_state[1]) |=> (pwr_state[1] || exit_blocked));

    p_sleep_window_r3: assert property (@(posedge clk) disable iff (rst)
        (!pwr_state[1]) |=> (!pwr_state[1] || entry_blocked));

    p_no_cross_r6: assert property (@(posedge clk) disable iff (rst)
        (pwr_state[1]) |=> (!pwr_state[1] || pwr_state == $past(pwr_state)));
endmodule

bind lps_seq_top lps_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ent_valid     (ent_valid),
    .exit_valid    (exit_valid),
    .row_pkt       (row_pkt),
    .col_pkt       (col_pkt),
    .viol_clr      (viol_clr),
    .pwr_state     (pwr_state),
    .entry_blocked (entry_blocked),
    .exit_blocked  (exit_blocked),
    .ent_viol      (ent_viol),
    .exit_viol     (exit_viol),
    .pkt_viol      (pkt_viol)
);

// File: tb/lps_seq_top_bench.sv
module lps_seq_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slow_tick = 1'b0;
    logic [3:0] cfg_napx = 4'd3;
    logic [2:0] cfg_pdnx = 3'd1;
    logic       cfg_nap_long = 1'b0;
    logic       cfg_pdn_long = 1'b1;
    logic       cfg_bcast = 1'b1;
    logic       cfg_slot = 1'b1;
    logic [5:0] cfg_dev_id = 6'd5;
    logic       ent_valid = 1'b0;
    logic       ent_kind = 1'b0;
    logic       ent_relax = 1'b0;
    logic       exit_valid = 1'b0;
    logic       exit_kind = 1'b0;
    logic [5:0] exit_dev = 6'd0;
    logic       row_pkt = 1'b0;
    logic       col_pkt = 1'b0;
    logic       viol_clr = 1'b0;
    logic [1:0] pwr_state;
    logic       entry_blocked, exit_blocked, ent_viol, exit_viol, pkt_viol;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    lps_seq_top u_lps_seq_top (
        .clk(clk), .rst(rst), .slow_tick(slow_tick),
        .cfg_napx(cfg_napx), .cfg_pdnx(cfg_pdnx),
        .cfg_nap_long(cfg_nap_long), .cfg_pdn_long(cfg_pdn_long),
        .cfg_bcast(cfg_bcast), .cfg_slot(cfg_slot), .cfg_dev_id(cfg_dev_id),
        .ent_valid(ent_valid), .ent_kind(ent_kind), .ent_relax(ent_relax),
        .exit_valid(exit_valid), .exit_kind(exit_kind), .exit_dev(exit_dev),
        .row_pkt(row_pkt), .col_pkt(col_pkt), .viol_clr(viol_clr),
        .pwr_state(pwr_state), .entry_blocked(entry_blocked),
        .exit_blocked(exit_blocked), .ent_viol(ent_viol),
        .exit_viol(exit_viol), .pkt_viol(pkt_viol)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock edge; outputs sampled at the following falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 state", pwr_state, 1);
        check("R1 entry_blocked", entry_blocked, 0);
        check("R1 exit_blocked", exit_blocked, 0);
        check("R1 flags", {ent_viol, exit_viol, pkt_viol}, 0);
    endtask

    task automatic t_nap_cycle();
        int bad = 0;
        slow_tick = 1'b1;
        ent_valid = 1'b1; ent_kind = 1'b0; ent_relax = 1'b0;
        step();
        ent_valid = 1'b0;
        check("R2 nap entry", pwr_state, 2);
        // 5 fast + (2+3) ticks: high for 9 more sampled cycles
        for (int i = 0; i < 9; i++) begin
            step();
            if (!entry_blocked) bad++;
        end
        check("R3 nap window held", bad, 0);
        step();
        check("R3 nap window end", entry_blocked, 0);
        slow_tick = 1'b0;
        exit_valid = 1'b1; exit_kind = 1'b0; cfg_bcast = 1'b1;
        step();
        exit_valid = 1'b0;
        check("R8 relax0 -> active", pwr_state, 0);
        check("R6 nap exit opens window", exit_blocked, 1);
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            step();
            if (!exit_blocked) bad++;
        end
        check("R9 short window held", bad, 0);
        step();
        check("R9 short window end", exit_blocked, 0);
    endtask

    task automatic t_pdn_cycle();
        int bad = 0;
        slow_tick = 1'b1;
        ent_valid = 1'b1; ent_kind = 1'b1; ent_relax = 1'b1;
        step();
        ent_valid = 1'b0;
        check("R2 pdn entry", pwr_state, 3);
        // 5 fast + (2+256) ticks
        for (int i = 0; i < 262; i++) begin
            step();
            if (!entry_blocked) bad++;
        end
        check("R4 pdn window held", bad, 0);
        step();
        check("R4 pdn window end", entry_blocked, 0);
        slow_tick = 1'b0;
        exit_valid = 1'b1; exit_kind = 1'b0;
        step();
        check("R6 kind mismatch ignored", pwr_state, 3);
        cfg_bcast = 1'b0; exit_kind = 1'b1; exit_dev = 6'd6;
        step();
        check("R7 address mismatch ignored", pwr_state, 3);
        exit_dev = 6'd5; cfg_slot = 1'b0;
        step();
        check("R7 slot 0 ignored", pwr_state, 3);
        cfg_slot = 1'b1;
        step();
        exit_valid = 1'b0;
        check("R8 relax1 -> standby", pwr_state, 1);
        check("R10 no exit flag yet", exit_viol, 0);
        bad = 0;
        for (int i = 0; i < 22; i++) begin
            if (i == 3) begin exit_valid = 1'b1; row_pkt = 1'b1; end
            step();
            exit_valid = 1'b0; row_pkt = 1'b0;
            if (!exit_blocked) bad++;
            if (i == 3) begin
                check("R10 exit in window flagged", exit_viol, 1);
                check("R10 exit in window ignored", pwr_state, 1);
                check("R11 row in window flagged", pkt_viol, 1);
            end
        end
        check("R9 long window held", bad, 0);
        step();
        check("R9 long window end", exit_blocked, 0);
    endtask

    task automatic t_entry_violation();
        viol_clr = 1'b1;
        step();
        viol_clr = 1'b0;
        check("R12 clear all", {ent_viol, exit_viol, pkt_viol}, 0);
        ent_valid = 1'b1; ent_kind = 1'b0; ent_relax = 1'b1;
        step();
        ent_valid = 1'b0;
        check("R2 nap entry again", pwr_state, 2);
        exit_valid = 1'b1; exit_kind = 1'b0; exit_dev = 6'd5;
        step();
        exit_valid = 1'b0;
        check("R7 addressed exit", pwr_state, 1);
        ent_valid = 1'b1; ent_kind = 1'b1;
        step();
        ent_valid = 1'b0;
        check("R5 entry in window ignored", pwr_state, 1);
        check("R5 entry flag", ent_viol, 1);
        step();
        check("R5 flag sticky", ent_viol, 1);
        viol_clr = 1'b1; ent_valid = 1'b1;
        step();
        viol_clr = 1'b0; ent_valid = 1'b0;
        check("R12 set wins over clear", ent_viol, 1);
        viol_clr = 1'b1;
        step();
        viol_clr = 1'b0;
        check("R12 clear alone", ent_viol, 0);
    endtask

    task automatic t_packet_same_cycle();
        slow_tick = 1'b1;
        repeat (20) step();
        slow_tick = 1'b0;
        check("R3 window gone", entry_blocked, 0);
        ent_valid = 1'b1; ent_kind = 1'b0; ent_relax = 1'b0;
        step();
        ent_valid = 1'b0;
        exit_valid = 1'b1; exit_kind = 1'b0; col_pkt = 1'b1;
        step();
        exit_valid = 1'b0; col_pkt = 1'b0;
        check("R8 back to active", pwr_state, 0);
        check("R11 packet with accepted exit", pkt_viol, 1);
        viol_clr = 1'b1;
        step();
        viol_clr = 1'b0;
        repeat (8) step();
        row_pkt = 1'b1; col_pkt = 1'b1;
        step();
        row_pkt = 1'b0; col_pkt = 1'b0;
        check("R11 packet outside interval", pkt_viol, 0);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_nap_cycle();
        t_pdn_cycle();
        t_entry_violation();
        t_packet_same_cycle();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule